// File: doc/BRIEF.md
# Reference Switcher with Phase-Step Absorber

This block sits in front of the digital PLL of a multi-trunk timing synchronizer. It receives a primary and a secondary reference clock at the same time. Both are synchronous to nothing, so each is passed through a two-stage synchronizer into the system clock domain. Only falling edges carry timing. One reference is active at a time, and each of its falling edges becomes a single-cycle pulse on the output edge stream that feeds the PLL. Both references must run at the same nominal rate. A 2-bit rate code gives that rate, and the block turns it into a nominal period counted in system clocks. The code is captured only while reset is held.

When the time-interval-error corrector is enabled, a change of the select input does not switch at once. The block first waits for two falling edges of the incoming reference, which is one full period of it. During that wait it keeps forwarding the outgoing reference. At the second incoming edge it timestamps both references against a free-running phase counter that wraps at the nominal period. It folds their difference into an accumulated delay, taken modulo the period, and from then on it releases every edge of the new reference late by that delay. The output phase therefore carries straight across the changeover. With the corrector disabled, the switch happens on the next clock and the new reference passes through without delay, so a phase step can reach the PLL. An active-reference status output and a one-cycle changeover pulse show what the selector did. The select and enable inputs are synchronous to the system clock.

Top module: `refsw_top`

## Requirements
- R1: While reset is held and after its release, until the first reference edge, `edge_out` and `switch_done` are 0 and `active_sec` is 0 (primary active).
- R2: Each falling edge of the active reference gives exactly one single-cycle pulse on `edge_out`. With the corrector disabled, the pulse is high in the cycle after the third rising clock edge that follows the reference fall.
- R3: The rate code `fsel` gives the nominal period in system clocks as round(SYS_CLK_HZ / f). Code 00 is 19.44 MHz, 01 is 8 kHz, 10 is 1.544 MHz and 11 is 2.048 MHz. With the default 77.76 MHz clock the periods are 4, 9720, 50 and 38 cycles. Corrected changeovers are seamless at each of these periods.
- R4: `fsel` is sampled only while `rst` is high. A change of `fsel` outside reset has no effect on the period the block uses.
- R5: With `tie_en` = 1, a changeover leaves every interval between output pulses within one cycle of the nominal period. The output keeps its phase relative to the reference that was active before.
- R6: With `tie_en` = 0, a changeover takes effect on the next clock with zero added delay. The output then follows the new reference with the R2 latency.
- R7: With `tie_en` = 1, the old reference stays forwarded until the second falling edge of the new reference after the select change. At that edge the switch completes.
- R8: `active_sec` shows the active reference (1 = secondary). It changes only in the cycle where `switch_done` pulses high for one cycle, and there is exactly one pulse per completed changeover.
- R9: If `sel_sec` returns to the active reference before a corrected changeover completes, the changeover is cancelled. There is no pulse on `switch_done`, `active_sec` keeps its value, and the output is undisturbed.
- R10: Offsets accumulate across changeovers. After switching away and back with the corrector on, the output keeps the phase it had before the first switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; captures `fsel` |
| ref_pri | input | 1 | Primary reference clock (asynchronous) |
| ref_sec | input | 1 | Secondary reference clock (asynchronous) |
| sel_sec | input | 1 | Requested reference: 0 primary, 1 secondary |
| tie_en | input | 1 | Enables phase-step absorption on changeover |
| fsel | input | 2 | Nominal reference rate code |
| edge_out | output | 1 | Corrected edge pulse stream to the PLL |
| active_sec | output | 1 | Active reference: 0 primary, 1 secondary |
| switch_done | output | 1 | One-cycle pulse when a changeover completes |

## Verification
The two references are driven at the nominal period, with the secondary offset by phase amounts that differ from test to test. Each of the four rate codes is used, so a wrong period or a wrong modulo reduction shows up as an interval that is off by more than one cycle. A corrected switch and a switch back are each judged by their output intervals and by the output delay measured from the primary's falls. An uncorrected switch is judged by the delay from the secondary's falls, which sets offset absorption apart from plain muxing. A select pulse that returns before the second incoming edge tests cancellation. A rate-code change outside reset, followed by a corrected switch, shows whether the held period was kept.

// File: rtl/refsw_pkg.sv
package refsw_pkg;

    localparam int unsigned NUM_REFS = 2;

    typedef enum logic [1:0] {
        FSEL_19M44 = 2'b00,
        FSEL_8K    = 2'b01,
        FSEL_1M544 = 2'b10,
        FSEL_2M048 = 2'b11
    } fsel_e;

    typedef enum logic [1:0] {
        SW_STEADY  = 2'd0,
        SW_ARM     = 2'd1,
        SW_MEASURE = 2'd2
    } sw_state_e;

    typedef struct packed {
        logic active;
        logic done;
    } sw_status_t;

    function automatic int unsigned ref_hz(input logic [1:0] code);
        case (fsel_e'(code))
            FSEL_19M44: return 19_440_000;
            FSEL_8K:    return 8_000;
            FSEL_1M544: return 1_544_000;
            default:    return 2_048_000;
        endcase
    endfunction

    function automatic int unsigned period_cycles(input int unsigned sys_hz,
                                                  input logic [1:0] code);
        int unsigned f;
        f = ref_hz(code);
        return (sys_hz + f / 2) / f;
    endfunction

    function automatic int unsigned max_period(input int unsigned sys_hz);
        int unsigned m;
        m = 1;
        for (int c = 0; c < 4; c++) begin
            if (period_cycles(sys_hz, 2'(c)) > m) m = period_cycles(sys_hz, 2'(c));
        end
        return m;
    endfunction

    // (acc + t_old - t_new) reduced into [0, per)
    function automatic int unsigned wrap_offset(input int unsigned acc,
                                                input int unsigned t_old,
                                                input int unsigned t_new,
                                                input int unsigned per);
        int unsigned x;
        x = acc + t_old + per - t_new;
        if (x >= 2 * per)  x = x - 2 * per;
        else if (x >= per) x = x - per;
        return x;
    endfunction

endpackage

// File: rtl/refsw_edge_detect.sv
module refsw_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_in,
    output logic fall
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[SH_W-2:0], ref_in};
    end

    // previous synchronized sample high, current low
    assign fall = sh_q[SH_W-1] & ~sh_q[SH_W-2];

endmodule

// File: rtl/refsw_phase_timer.sv
module refsw_phase_timer
    import refsw_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [CNT_W-1:0]                   period,
    input  logic [NUM_REFS-1:0]                fall,
    output logic [CNT_W-1:0]                   phase,
    output logic [NUM_REFS-1:0][CNT_W-1:0]     stamp
);
    always_ff @(posedge clk) begin
        if (rst)                              phase <= '0;
        else if (phase >= period - CNT_W'(1)) phase <= '0;
        else                                  phase <= phase + CNT_W'(1);
    end

    for (genvar g = 0; g < NUM_REFS; g++) begin : g_stamp
        always_ff @(posedge clk) begin
            if (rst)          stamp[g] <= '0;
            else if (fall[g]) stamp[g] <= phase;
        end
    end

endmodule

// File: rtl/refsw_switch_ctrl.sv
module refsw_switch_ctrl
    import refsw_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           sel_sec,
    input  logic                           tie_en,
    input  logic [NUM_REFS-1:0]            fall,
    input  logic [CNT_W-1:0]               phase,
    input  logic [NUM_REFS-1:0][CNT_W-1:0] stamp,
    input  logic [CNT_W-1:0]               period,
    output logic                           launch,
    output logic [CNT_W-1:0]               launch_dly,
    output logic [CNT_W-1:0]               ofs,
    output sw_status_t                     status
);
    sw_state_e        state_q;
    logic             act_q;
    logic             done_q;
    logic [CNT_W-1:0] ofs_q;

    logic             tgt;
    logic             want_switch;
    logic [CNT_W-1:0] old_ts;
    logic [CNT_W-1:0] ofs_next;
    logic             latch;

    always_comb begin
        tgt         = ~act_q;
        want_switch = (sel_sec != act_q);
        old_ts      = fall[act_q] ? phase : stamp[act_q];
        ofs_next    = CNT_W'(wrap_offset(32'(ofs_q), 32'(old_ts),
                                         32'(phase), 32'(period)));
        latch       = tie_en && (state_q == SW_MEASURE) && want_switch && fall[tgt];
        launch      = latch | fall[act_q];
        if (latch)       launch_dly = ofs_next;
        else if (tie_en) launch_dly = ofs_q;
        else             launch_dly = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SW_STEADY;
            act_q   <= 1'b0;
            ofs_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!tie_en) begin
                state_q <= SW_STEADY;
                ofs_q   <= '0;
                if (want_switch) begin
                    act_q  <= tgt;
                    done_q <= 1'b1;
                end
            end else begin
                case (state_q)
                    SW_STEADY: begin
                        if (want_switch) state_q <= SW_ARM;
                    end
                    SW_ARM: begin
                        if (!want_switch)  state_q <= SW_STEADY;
                        else if (fall[tgt]) state_q <= SW_MEASURE;
                    end
                    SW_MEASURE: begin
                        if (!want_switch) begin
                            state_q <= SW_STEADY;
                        end else if (fall[tgt]) begin
                            act_q   <= tgt;
                            ofs_q   <= ofs_next;
                            done_q  <= 1'b1;
                            state_q <= SW_STEADY;
                        end
                    end
                    default: state_q <= SW_STEADY;
                endcase
            end
        end
    end

    assign ofs           = ofs_q;
    assign status.active = act_q;
    assign status.done   = done_q;

endmodule

// File: rtl/refsw_edge_delay.sv
module refsw_edge_delay #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch,
    input  logic [CNT_W-1:0] launch_dly,
    output logic             edge_out
);
    logic             pend_q;
    logic [CNT_W-1:0] cnt_q;
    logic             fire;

    assign fire = (launch && (launch_dly == '0)) || (pend_q && (cnt_q == CNT_W'(1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= 1'b0;
            cnt_q    <= '0;
            edge_out <= 1'b0;
        end else begin
            edge_out <= fire;
            if (launch && (launch_dly != '0)) begin
                pend_q <= 1'b1;
                cnt_q  <= launch_dly;
            end else if (pend_q) begin
                cnt_q <= cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) pend_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/refsw_top.sv
module refsw_top
    import refsw_pkg::*;
#(
    parameter int unsigned SYS_CLK_HZ  = 77_760_000,
    parameter int          SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_pri,
    input  logic       ref_sec,
    input  logic       sel_sec,
    input  logic       tie_en,
    input  logic [1:0] fsel,
    output logic       edge_out,
    output logic       active_sec,
    output logic       switch_done
);
    localparam int unsigned MAXP  = max_period(SYS_CLK_HZ);
    localparam int          CNT_W = $clog2(MAXP + 1);
    localparam logic [CNT_W-1:0] PER_19M44 = CNT_W'(period_cycles(SYS_CLK_HZ, 2'b00));
    localparam logic [CNT_W-1:0] PER_8K    = CNT_W'(period_cycles(SYS_CLK_HZ, 2'b01));
    localparam logic [CNT_W-1:0] PER_1M544 = CNT_W'(period_cycles(SYS_CLK_HZ, 2'b10));
    localparam logic [CNT_W-1:0] PER_2M048 = CNT_W'(period_cycles(SYS_CLK_HZ, 2'b11));

    logic [1:0]                     code_q;
    logic [CNT_W-1:0]               period;
    logic [NUM_REFS-1:0]            ref_vec;
    logic [NUM_REFS-1:0]            fall;
    logic [CNT_W-1:0]               phase;
    logic [NUM_REFS-1:0][CNT_W-1:0] stamp;
    logic                           launch;
    logic [CNT_W-1:0]               launch_dly;
    logic [CNT_W-1:0]               sw_ofs;
    sw_status_t                     status;

    // rate code held from reset
    always_ff @(posedge clk) begin
        if (rst) code_q <= fsel;
    end

    always_comb begin
        case (fsel_e'(code_q))
            FSEL_19M44: period = PER_19M44;
            FSEL_8K:    period = PER_8K;
            FSEL_1M544: period = PER_1M544;
            default:    period = PER_2M048;
        endcase
    end

    assign ref_vec = {ref_sec, ref_pri};

    for (genvar g = 0; g < NUM_REFS; g++) begin : g_ref
        refsw_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det (
            .clk    (clk),
            .rst    (rst),
            .ref_in (ref_vec[g]),
            .fall   (fall[g])
        );
    end

    refsw_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .period (period),
        .fall   (fall),
        .phase  (phase),
        .stamp  (stamp)
    );

    refsw_switch_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .sel_sec    (sel_sec),
        .tie_en     (tie_en),
        .fall       (fall),
        .phase      (phase),
        .stamp      (stamp),
        .period     (period),
        .launch     (launch),
        .launch_dly (launch_dly),
        .ofs        (sw_ofs),
        .status     (status)
    );

    refsw_edge_delay #(.CNT_W(CNT_W)) u_delay (
        .clk        (clk),
        .rst        (rst),
        .launch     (launch),
        .launch_dly (launch_dly),
        .edge_out   (edge_out)
    );

    assign active_sec  = status.active;
    assign switch_done = status.done;

endmodule

// File: rtl/refsw_checker.sv
module refsw_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             tie_en,
    input logic             edge_out,
    input logic             active_sec,
    input logic             switch_done,
    input logic [1:0]       code_q,
    input logic [CNT_W-1:0] ofs,
    input logic [CNT_W-1:0] period
);
    assert_edge_single_R2: assert property (@(posedge clk) disable iff (rst)
        edge_out |=> !edge_out);

    assert_code_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(code_q));

    assert_ofs_range_R5: assert property (@(posedge clk) disable iff (rst)
        ofs < period);

    assert_ofs_clear_R6: assert property (@(posedge clk) disable iff (rst)
        !tie_en |=> (ofs == '0));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        switch_done |=> !switch_done);

    assert_active_with_done_R8: assert property (@(posedge clk) disable iff (rst)
        (active_sec != $past(active_sec)) |-> switch_done);

endmodule

bind refsw_top refsw_checker #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tie_en      (tie_en),
    .edge_out    (edge_out),
    .active_sec  (active_sec),
    .switch_done (switch_done),
    .code_q      (code_q),
    .ofs         (sw_ofs),
    .period      (period)
);

// File: tb/refsw_top_tb.sv
module refsw_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190_000;
    localparam int LAT        = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_pri = 1'b0;
    logic       ref_sec = 1'b0;
    logic       sel_sec = 1'b0;
    logic       tie_en = 1'b0;
    logic [1:0] fsel = 2'b11;
    logic       edge_out, active_sec, switch_done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // generator and monitor state
    int  per = 38;
    int  cnt_a = 0, cnt_b = 0;
    bit  gen_on = 0;
    int  cyc = 0;
    int  last_fall_a = 0, last_fall_b = 0;
    int  falls_a = 0, falls_b = 0;
    int  last_out = 0;
    bit  have_prev = 0;
    int  iv_min = 0, iv_max = 0, n_iv = 0;
    int  n_out = 0, n_done = 0;
    int  dly_a = 0, dly_b = 0;
    int  falls_b_at_done = 0;

    refsw_top u_dut (
        .clk         (clk),
        .rst         (rst),
        .ref_pri     (ref_pri),
        .ref_sec     (ref_sec),
        .sel_sec     (sel_sec),
        .tie_en      (tie_en),
        .fsel        (fsel),
        .edge_out    (edge_out),
        .active_sec  (active_sec),
        .switch_done (switch_done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(negedge clk) begin
        bit na, nb;
        int iv;
        cyc++;
        if (gen_on) begin
            cnt_a = (cnt_a + 1) % per;
            cnt_b = (cnt_b + 1) % per;
            na = (cnt_a < per / 2);
            nb = (cnt_b < per / 2);
            if (ref_pri && !na) begin last_fall_a = cyc; falls_a++; end
            if (ref_sec && !nb) begin last_fall_b = cyc; falls_b++; end
            ref_pri = na;
            ref_sec = nb;
        end
        if (edge_out) begin
            if (have_prev) begin
                iv = cyc - last_out;
                if (n_iv == 0 || iv < iv_min) iv_min = iv;
                if (n_iv == 0 || iv > iv_max) iv_max = iv;
                n_iv++;
            end
            have_prev = 1;
            last_out  = cyc;
            n_out++;
            dly_a = (cyc - last_fall_a) % per;
            dly_b = (cyc - last_fall_b) % per;
        end
        if (switch_done) begin
            n_done++;
            falls_b_at_done = falls_b;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_stats();
        n_iv = 0; n_out = 0; n_done = 0;
    endtask

    task automatic run_periods(input int n);
        repeat (n * per) @(negedge clk);
        #1;
    endtask

    task automatic wait_fall_a();
        int m;
        m = falls_a;
        while (falls_a == m) @(negedge clk);
        #1;
    endtask

    task automatic setup(input logic [1:0] code, input int p, input int off_b, input bit tie);
        @(negedge clk); #1;
        gen_on  = 0;
        rst     = 1'b1;
        fsel    = code;
        tie_en  = tie;
        sel_sec = 1'b0;
        per     = p;
        cnt_a   = 0;
        cnt_b   = off_b;
        ref_pri = 1'b1;
        ref_sec = (off_b < p / 2);
        repeat (4) @(negedge clk);
        #1;
        rst    = 1'b0;
        gen_on = 1;
        run_periods(2);
        have_prev = 0;
        clear_stats();
    endtask

    task automatic check_intervals(input string tag);
        check(n_iv > 0, tag, n_iv, 1);
        check(iv_min >= per - 1, tag, iv_min, per);
        check(iv_max <= per + 1, tag, iv_max, per);
    endtask

    // corrected changeover A->B, optional check of the two-edge wait
    task automatic corrected_switch(input string tag, input bit chk_wait);
        int fb;
        wait_fall_a();
        fb = falls_b;
        sel_sec = 1'b1;
        run_periods(6);
        check(active_sec == 1'b1, {tag, " R8 active"}, active_sec, 1);
        check(n_done == 1, {tag, " R8 done count"}, n_done, 1);
        if (chk_wait)
            check(falls_b_at_done - fb == 2, {tag, " R7 edges before switch"},
                  falls_b_at_done - fb, 2);
        check_intervals({tag, " R5 intervals"});
        check(dly_a == LAT % per, {tag, " R5 phase kept"}, dly_a, LAT % per);
    endtask

    task automatic t_reset_state();
        @(negedge clk); #1;
        rst = 1'b1;
        gen_on = 0;
        repeat (3) @(negedge clk);
        #1;
        check(edge_out == 1'b0, "R1 edge_out in reset", edge_out, 0);
        check(active_sec == 1'b0, "R1 active_sec in reset", active_sec, 0);
        check(switch_done == 1'b0, "R1 switch_done in reset", switch_done, 0);
        rst = 1'b0;
        @(negedge clk); #1;
        check(edge_out == 1'b0, "R1 edge_out after reset", edge_out, 0);
        check(active_sec == 1'b0, "R1 active_sec after reset", active_sec, 0);
    endtask

    task automatic t_pass_through();
        setup(2'b11, 38, 13, 1'b0);
        run_periods(8);
        check_intervals("R2 pass-through intervals");
        check(n_out >= 7, "R2 pulse count", n_out, 8);
        check(dly_a == LAT, "R2 latency", dly_a, LAT);
        check(n_done == 0, "R8 no spurious done", n_done, 0);
    endtask

    task automatic t_switch_and_back();
        setup(2'b11, 38, 13, 1'b1);
        corrected_switch("main", 1'b1);
        check(dly_b != LAT, "R5 correction applied", dly_b, -1);
        clear_stats();
        wait_fall_a();
        sel_sec = 1'b0;
        run_periods(6);
        check(active_sec == 1'b0, "R10 back on primary", active_sec, 0);
        check(n_done == 1, "R10 done count", n_done, 1);
        check_intervals("R10 intervals");
        check(dly_a == LAT, "R10 accumulated phase", dly_a, LAT);
    endtask

    task automatic t_abort();
        int fb;
        setup(2'b11, 38, 13, 1'b1);
        wait_fall_a();
        fb = falls_b;
        sel_sec = 1'b1;
        while (falls_b == fb) @(negedge clk);
        repeat (8) @(negedge clk);
        #1;
        sel_sec = 1'b0;
        run_periods(5);
        check(n_done == 0, "R9 no done after cancel", n_done, 0);
        check(active_sec == 1'b0, "R9 active unchanged", active_sec, 0);
        check_intervals("R9 intervals");
        check(dly_a == LAT, "R9 phase", dly_a, LAT);
    endtask

    task automatic t_tie_off_switch();
        setup(2'b11, 38, 13, 1'b0);
        wait_fall_a();
        sel_sec = 1'b1;
        @(negedge clk); #1;
        check(active_sec == 1'b1, "R6 immediate switch", active_sec, 1);
        check(n_done == 1, "R6 done pulse", n_done, 1);
        run_periods(4);
        check(dly_b == LAT, "R6 follows new reference", dly_b, LAT);
        check(dly_a != LAT, "R6 phase step present", dly_a, -1);
    endtask

    task automatic t_code_hold();
        setup(2'b11, 38, 13, 1'b1);
        fsel = 2'b10;
        run_periods(2);
        clear_stats();
        corrected_switch("R4 code change ignored", 1'b0);
    endtask

    task automatic t_code_variant(input logic [1:0] code, input int p, input int off_b,
                                  input string tag);
        setup(code, p, off_b, 1'b1);
        corrected_switch(tag, 1'b0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_pass_through();
        t_switch_and_back();
        t_abort();
        t_tie_off_switch();
        t_code_hold();
        t_code_variant(2'b10, 50, 21, "R3 code 10");
        t_code_variant(2'b00, 4, 1, "R3 code 00");
        t_code_variant(2'b01, 9720, 3000, "R3 code 01");
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule